// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide host side of a three-channel interval timer. A host reaches it through a 2-bit address. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port. The block decodes control words into per-channel configuration, counter-latch commands and read-back commands. It builds 16-bit initial counts out of byte writes and hands each count to its channel core as a one-cycle load pulse. It returns 16-bit counts one byte at a time.

Each channel core supplies its live count and its output level. The block passes the operating mode and the decimal-counting flag back to each core. A latched count or status byte is held until the host has read it, and reads follow a fixed priority. The counting itself happens in the channel cores and is outside this block.

Reads are combinational. `bus_rdata` is valid while `bus_rd` is high, and the side effects of a read, such as releasing a latch or advancing the byte toggle, take place at the clock edge that samples the strobe. Side effects of writes also take effect at the sampling edge. A load pulse appears in the cycle after that edge.

Top module: `tmr_host_if`

## Requirements
- R1: After reset, no count or status latch is pending and both byte toggles of every channel are clear. Every channel is in access mode 3 (low byte then high byte), operating mode 0, with the decimal flag 0. No load pulse is active.
- R2: A control-port write decodes as follows:
  - bits 7:6 select the channel, and the value 3 means read-back;
  - bits 5:4 select the access mode (1 = low only, 2 = high only, 3 = low then high), and the value 0 is a counter-latch command that changes no configuration;
  - bits 3:1 give the operating mode and bit 0 the decimal flag, and `ch_mode`/`ch_bcd` show the new values from the next cycle;
  - a nonzero access field also clears that channel's write and read byte toggles.
- R3: In access mode 1, a data write loads {8'h00, byte}. In access mode 2, it loads {byte, 8'h00}. In both cases `ch_load` pulses for the addressed channel in the cycle after the write.
- R4: In access mode 3, the first data write is only held and produces no load. The second write loads {second, first}.
- R5: A counter-latch command captures the live count at its write edge. Reads then return the captured value by access mode: mode 1 gives the low byte once, mode 2 gives the high byte once, and mode 3 gives the low byte then the high byte. After that the latch is released.
- R6: A read-back command (bits 7:6 = 3) acts on each channel c whose bit c+1 is 1. For every selected channel, bit 5 = 0 latches the count and bit 4 = 0 latches the status, so several channels can be latched at once.
- R7: A latched status byte is {output level, 1'b0, access mode[1:0], operating mode[2:0], decimal flag}, with the output level being the one present at the command edge.
- R8: A count-latch request is ignored while an earlier latched count is unread, including one that is half read. A status-latch request is ignored while an earlier status byte is unread.
- R9: A data-port read returns a pending status byte first (releasing it), then the latched count bytes, and only then the live count.
- R10: An unlatched read returns live count bytes: mode 1 always returns the low byte, mode 2 always the high byte, and mode 3 alternates low, high on successive reads.
- R11: A control-port write never pulses `ch_load`. At most one channel loads per cycle. A read of address 3 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | 0..2 channel data port, 3 control port |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Read byte, valid while bus_rd is high |
| ch_count_in | input | 48 | Live 16-bit count of each channel, channel 0 in the low bits |
| ch_out_in | input | 3 | Output level of each channel |
| ch_load | output | 3 | One-cycle load pulse per channel |
| ch_load_val | output | 16 | Count that goes with the active load pulse |
| ch_mode | output | 9 | 3-bit operating mode per channel, channel 0 in the low bits |
| ch_bcd | output | 3 | Decimal-counting flag per channel |

## Verification
The properties assume that `bus_rd` and `bus_wr` are never high in the same cycle. The block resolves such a collision in favour of the write, but the assertions about latch release and stability are written for exclusive strobes. The stimulus drives each strobe for exactly one cycle from tasks that return with both strobes low, so no overlap occurs. The properties also assume that the live counts may change in any cycle. To cover this, the bench moves the live counts between latch and read so that latched and live values always differ.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int ADDR_W   = 2;
    localparam int MODE_W   = 3;
    localparam int MAX_CH   = 3;
    localparam logic [ADDR_W-1:0] CTL_ADDR = 2'd3;
    localparam logic [1:0]        RB_SEL   = 2'd3;

    // access field of a control word
    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    // what remains to be read from a latched count
    typedef enum logic [1:0] {
        LQ_NONE = 2'd0,
        LQ_LO   = 2'd1,
        LQ_HI   = 2'd2,
        LQ_WORD = 2'd3
    } lq_e;

    typedef struct packed {
        logic [1:0]        sel;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ctl_word_t;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ch_cfg_t;

    function automatic logic [BYTE_W-1:0] make_status(
        input logic    out_lvl,
        input ch_cfg_t cfg
    );
        return {out_lvl, 1'b0, cfg.acc, cfg.mode, cfg.bcd};
    endfunction

    function automatic lq_e latch_kind(input acc_e acc);
        lq_e k;
        case (acc)
            ACC_LO:   k = LQ_LO;
            ACC_HI:   k = LQ_HI;
            ACC_WORD: k = LQ_WORD;
            default:  k = LQ_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
    import tmr_host_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [NUM_CH-1:0]    cfg_we,
    output logic [NUM_CH-1:0]    cnt_latch,
    output logic [NUM_CH-1:0]    sts_latch
);
    ctl_word_t cw;
    logic      ctl_hit;
    logic      rb_hit;

    assign cw      = ctl_word_t'(wdata);
    assign ctl_hit = wr_en && (addr == CTL_ADDR);
    assign rb_hit  = ctl_hit && (cw.sel == RB_SEL);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_hit;
        logic rb_pick;
        assign sel_hit      = ctl_hit && (cw.sel == 2'(c));
        assign rb_pick      = rb_hit && wdata[1 + c];
        assign cfg_we[c]    = sel_hit && (cw.acc != ACC_LATCH);
        assign cnt_latch[c] = (sel_hit && (cw.acc == ACC_LATCH)) ||
                              (rb_pick && !wdata[5]);
        assign sts_latch[c] = rb_pick && !wdata[4];
    end

endmodule

// File: rtl/tmr_wr_seq.sv
module tmr_wr_seq
    import tmr_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              data_we,
    input  acc_e              acc,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              load,
    output logic [CNT_W-1:0]  load_val
);
    logic              wr_hi;
    logic [BYTE_W-1:0] lo_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_hi    <= 1'b0;
            lo_hold  <= '0;
            load     <= 1'b0;
            load_val <= '0;
        end else begin
            load <= 1'b0;
            if (cfg_we) begin
                wr_hi <= 1'b0;
            end else if (data_we) begin
                case (acc)
                    ACC_LO: begin
                        load     <= 1'b1;
                        load_val <= {{BYTE_W{1'b0}}, wbyte};
                    end
                    ACC_HI: begin
                        load     <= 1'b1;
                        load_val <= {wbyte, {BYTE_W{1'b0}}};
                    end
                    ACC_WORD: begin
                        if (!wr_hi) begin
                            lo_hold <= wbyte;
                            wr_hi   <= 1'b1;
                        end else begin
                            load     <= 1'b1;
                            load_val <= {wbyte, lo_hold};
                            wr_hi    <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tmr_rd_seq.sv
module tmr_rd_seq
    import tmr_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cnt_latch,
    input  logic              sts_latch,
    input  logic              rd_en,
    input  ch_cfg_t           cfg,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    output logic [BYTE_W-1:0] rdata,
    output logic              sts_pend,
    output logic              cnt_pend,
    output logic [CNT_W-1:0]  cnt_hold
);
    lq_e               lq;
    logic              rd_hi;
    logic [BYTE_W-1:0] sts_q;

    assign cnt_pend = (lq != LQ_NONE);

    always_comb begin
        if (sts_pend) begin
            rdata = sts_q;
        end else begin
            case (lq)
                LQ_LO, LQ_WORD: rdata = cnt_hold[BYTE_W-1:0];
                LQ_HI:          rdata = cnt_hold[CNT_W-1:BYTE_W];
                default: begin
                    case (cfg.acc)
                        ACC_HI:   rdata = live_cnt[CNT_W-1:BYTE_W];
                        ACC_WORD: rdata = rd_hi ? live_cnt[CNT_W-1:BYTE_W]
                                                : live_cnt[BYTE_W-1:0];
                        default:  rdata = live_cnt[BYTE_W-1:0];
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lq       <= LQ_NONE;
            rd_hi    <= 1'b0;
            sts_q    <= '0;
            sts_pend <= 1'b0;
            cnt_hold <= '0;
        end else begin
            if (rd_en) begin
                if (sts_pend) begin
                    sts_pend <= 1'b0;
                end else if (lq != LQ_NONE) begin
                    lq <= (lq == LQ_WORD) ? LQ_HI : LQ_NONE;
                end else if (cfg.acc == ACC_WORD) begin
                    rd_hi <= !rd_hi;
                end
            end
            if (cfg_we) begin
                rd_hi <= 1'b0;
            end
            if (cnt_latch && (lq == LQ_NONE)) begin
                cnt_hold <= live_cnt;
                lq       <= latch_kind(cfg.acc);
            end
            if (sts_latch && !sts_pend) begin
                sts_q    <= make_status(out_lvl, cfg);
                sts_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cnt_latch,
    input  logic              sts_latch,
    input  logic              data_we,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    output logic [BYTE_W-1:0] rdata,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output ch_cfg_t           cfg,
    output logic              sts_pend,
    output logic              cnt_pend,
    output logic [CNT_W-1:0]  cnt_hold
);
    ctl_word_t cw;
    assign cw = ctl_word_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.acc  <= ACC_WORD;
            cfg.mode <= '0;
            cfg.bcd  <= 1'b0;
        end else if (cfg_we) begin
            cfg.acc  <= cw.acc;
            cfg.mode <= cw.mode;
            cfg.bcd  <= cw.bcd;
        end
    end

    tmr_wr_seq u_wr (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .data_we  (data_we),
        .acc      (cfg.acc),
        .wbyte    (wdata),
        .load     (load),
        .load_val (load_val)
    );

    tmr_rd_seq u_rd (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cnt_latch (cnt_latch),
        .sts_latch (sts_latch),
        .rd_en     (rd_en),
        .cfg       (cfg),
        .live_cnt  (live_cnt),
        .out_lvl   (out_lvl),
        .rdata     (rdata),
        .sts_pend  (sts_pend),
        .cnt_pend  (cnt_pend),
        .cnt_hold  (cnt_hold)
    );

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
    import tmr_host_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [BYTE_W-1:0]        bus_wdata,
    input  logic                     bus_rd,
    output logic [BYTE_W-1:0]        bus_rdata,
    input  logic [NUM_CH*CNT_W-1:0]  ch_count_in,
    input  logic [NUM_CH-1:0]        ch_out_in,
    output logic [NUM_CH-1:0]        ch_load,
    output logic [CNT_W-1:0]         ch_load_val,
    output logic [NUM_CH*MODE_W-1:0] ch_mode,
    output logic [NUM_CH-1:0]        ch_bcd
);
    logic [NUM_CH-1:0]             cfg_we;
    logic [NUM_CH-1:0]             cnt_latch;
    logic [NUM_CH-1:0]             sts_latch;
    logic [NUM_CH-1:0]             sts_pend;
    logic [NUM_CH-1:0]             cnt_pend;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_hold;
    logic [NUM_CH-1:0][BYTE_W-1:0] rdata_ch;
    logic [NUM_CH-1:0][CNT_W-1:0]  load_val_ch;
    logic                          wr_en;
    logic                          rd_en;

    // a write wins if both strobes appear together
    assign wr_en = bus_wr;
    assign rd_en = bus_rd && !bus_wr;

    tmr_ctl_decode #(.NUM_CH(NUM_CH)) u_dec (
        .wr_en     (wr_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .cfg_we    (cfg_we),
        .cnt_latch (cnt_latch),
        .sts_latch (sts_latch)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ch_cfg_t cfg_c;
        logic    hit;
        assign hit = (bus_addr == 2'(c));

        tmr_chan_port u_port (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we[c]),
            .cnt_latch (cnt_latch[c]),
            .sts_latch (sts_latch[c]),
            .data_we   (wr_en && hit),
            .rd_en     (rd_en && hit),
            .wdata     (bus_wdata),
            .live_cnt  (ch_count_in[c*CNT_W +: CNT_W]),
            .out_lvl   (ch_out_in[c]),
            .rdata     (rdata_ch[c]),
            .load      (ch_load[c]),
            .load_val  (load_val_ch[c]),
            .cfg       (cfg_c),
            .sts_pend  (sts_pend[c]),
            .cnt_pend  (cnt_pend[c]),
            .cnt_hold  (cnt_hold[c])
        );

        assign ch_mode[c*MODE_W +: MODE_W] = cfg_c.mode;
        assign ch_bcd[c]                   = cfg_c.bcd;
    end

    always_comb begin
        ch_load_val = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_load[c]) ch_load_val = ch_load_val | load_val_ch[c];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == 2'(c)) bus_rdata = rdata_ch[c];
        end
    end

endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk
    import tmr_host_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_wr,
    input logic [BYTE_W-1:0]        bus_wdata,
    input logic                     bus_rd,
    input logic [NUM_CH-1:0]        ch_load,
    input logic [NUM_CH*MODE_W-1:0] ch_mode,
    input logic [NUM_CH-1:0]        sts_pend,
    input logic [NUM_CH-1:0]        cnt_pend,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_hold
);
    assert_load_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_load));

    assert_load_cause_R3: assert property (@(posedge clk) disable iff (rst)
        (|ch_load) |-> ($past(bus_wr) && ($past(bus_addr) != CTL_ADDR)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic rd_c;
        assign rd_c = bus_rd && !bus_wr && (bus_addr == 2'(c));

        assert_mode_R2: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == CTL_ADDR && bus_wdata[7:6] == 2'(c) &&
             bus_wdata[5:4] != 2'b00)
            |=> (ch_mode[c*MODE_W +: MODE_W] == $past(bus_wdata[3:1])));

        assert_sts_release_R9: assert property (@(posedge clk) disable iff (rst)
            (rd_c && sts_pend[c]) |=> (!sts_pend[c] && $stable(cnt_pend[c])));

        assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
            (cnt_pend[c] && !rd_c) |=> $stable(cnt_hold[c]));
    end

endmodule

bind tmr_host_if tmr_host_if_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sim_tmr_host_if.sv
module sim_tmr_host_if;
    localparam int CLK_P  = 10;
    localparam int NUM_CH = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       bus_addr;
    logic             bus_wr;
    logic [7:0]       bus_wdata;
    logic             bus_rd;
    logic [7:0]       bus_rdata;
    logic [2:0][15:0] live;
    logic [2:0]       outs;
    logic [2:0]       ch_load;
    logic [15:0]      ch_load_val;
    logic [8:0]       ch_mode;
    logic [2:0]       ch_bcd;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tmr_host_if #(.NUM_CH(NUM_CH)) u0 (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .ch_count_in (live),
        .ch_out_in   (outs),
        .ch_load     (ch_load),
        .ch_load_val (ch_load_val),
        .ch_mode     (ch_mode),
        .ch_bcd      (ch_bcd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    function automatic logic [7:0] cword(int ch, int acc, int md, int b);
        return {2'(ch), 2'(acc), 3'(md), 1'(b)};
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        live = {16'h3322, 16'h2211, 16'h1100};
        outs = 3'b000;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 load", int'(ch_load), 0);
        chk("R1 mode", int'(ch_mode), 0);
        chk("R1 bcd", int'(ch_bcd), 0);
        for (int c = 0; c < 3; c++) begin
            rd(2'(c), d); chk("R1 live lo", d, live[c][7:0]);
            rd(2'(c), d); chk("R1 live hi", d, live[c][15:8]);
        end

        // sweep: channel x access x mode x decimal flag
        for (int ch = 0; ch < 3; ch++) begin
            for (int acc = 1; acc < 4; acc++) begin
                for (int md = 0; md < 6; md++) begin
                    for (int b = 0; b < 2; b++) begin
                        logic [7:0] b1, b2;
                        b1 = 8'(ch * 40 + md * 7 + acc + b + 1);
                        b2 = ~b1 ^ 8'(md);
                        wr(2'd3, cword(ch, acc, md, b));
                        chk("R11 no load on ctl", int'(ch_load), 0);
                        chk("R2 mode", int'(ch_mode[ch*3 +: 3]), md);
                        chk("R2 bcd", int'(ch_bcd[ch]), b);
                        if (acc == 1) begin
                            wr(2'(ch), b1);
                            chk("R3 lo load", int'(ch_load), 1 << ch);
                            chk("R3 lo val", int'(ch_load_val), int'({8'h00, b1}));
                        end else if (acc == 2) begin
                            wr(2'(ch), b1);
                            chk("R3 hi load", int'(ch_load), 1 << ch);
                            chk("R3 hi val", int'(ch_load_val), int'({b1, 8'h00}));
                        end else begin
                            wr(2'(ch), b1);
                            chk("R4 first held", int'(ch_load), 0);
                            wr(2'(ch), b2);
                            chk("R4 word load", int'(ch_load), 1 << ch);
                            chk("R4 word val", int'(ch_load_val), int'({b2, b1}));
                        end
                        live[ch] = {b2, b1};
                        rd(2'(ch), d);
                        chk("R10 first", d, (acc == 2) ? b2 : b1);
                        rd(2'(ch), d);
                        chk("R10 second", d, (acc == 1) ? b1 : b2);
                        outs[ch] = 1'(md[0] ^ b[0]);
                        wr(2'd3, 8'hE0 | 8'(1 << (ch + 1)));
                        outs[ch] = ~outs[ch];
                        rd(2'(ch), d);
                        chk("R7 status", d,
                            int'({~outs[ch], 1'b0, 2'(acc), 3'(md), 1'(b)}));
                        rd(2'(ch), d);
                        chk("R9 live after status", d, (acc == 2) ? b2 : b1);
                    end
                end
            end
        end

        // counter-latch command per access mode
        for (int ch = 0; ch < 3; ch++) begin
            for (int acc = 1; acc < 4; acc++) begin
                logic [15:0] v1, v2;
                v1 = 16'hA005 | 16'(ch << 8) | 16'(acc << 4);
                v2 = ~v1;
                wr(2'd3, cword(ch, acc, 2, 0));
                live[ch] = v1;
                wr(2'd3, cword(ch, 0, 0, 0));
                chk("R5 latch keeps mode", int'(ch_mode[ch*3 +: 3]), 2);
                live[ch] = v2;
                wr(2'd3, cword(ch, 0, 0, 0));
                if (acc == 1) begin
                    rd(2'(ch), d); chk("R8 R5 latched lo", d, v1[7:0]);
                    rd(2'(ch), d); chk("R5 released lo", d, v2[7:0]);
                end else if (acc == 2) begin
                    rd(2'(ch), d); chk("R8 R5 latched hi", d, v1[15:8]);
                    rd(2'(ch), d); chk("R5 released hi", d, v2[15:8]);
                end else begin
                    rd(2'(ch), d); chk("R5 latched word lo", d, v1[7:0]);
                    wr(2'd3, cword(ch, 0, 0, 0));
                    rd(2'(ch), d); chk("R8 half read hi", d, v1[15:8]);
                    rd(2'(ch), d); chk("R5 live lo", d, v2[7:0]);
                    rd(2'(ch), d); chk("R5 live hi", d, v2[15:8]);
                end
            end
        end

        // R8 status latch ignored while unread
        wr(2'd3, cword(1, 3, 4, 1));
        outs[1] = 1'b1;
        wr(2'd3, 8'hE4);
        outs[1] = 1'b0;
        wr(2'd3, 8'hE4);
        rd(2'd1, d);
        chk("R8 status kept", d, int'({1'b1, 1'b0, 2'd3, 3'd4, 1'b1}));

        // R6 read-back of all channels, count and status
        for (int c = 0; c < 3; c++) wr(2'd3, cword(c, 3, c, 0));
        live = {16'hC2B2, 16'hC1B1, 16'hC0B0};
        outs = 3'b101;
        wr(2'd3, 8'hCE);
        live = {16'h0F0F, 16'h0E0E, 16'h0D0D};
        outs = 3'b010;
        for (int c = 0; c < 3; c++) begin
            rd(2'(c), d);
            chk("R6 R9 status first", d,
                int'({c != 1, 1'b0, 2'd3, 3'(c), 1'b0}));
            rd(2'(c), d); chk("R6 count lo", d, 8'hB0 + 8'(c));
            rd(2'(c), d); chk("R6 count hi", d, 8'hC0 + 8'(c));
            rd(2'(c), d); chk("R6 live after", d, live[c][7:0]);
            rd(2'(c), d);
        end

        // R6 read-back selecting only channel 1 count
        live = {16'h5544, 16'h7766, 16'h9988};
        wr(2'd3, 8'hD4);
        live = {16'h1111, 16'h2222, 16'h3333};
        rd(2'd0, d); chk("R6 unselected ch0 live", d, 8'h33);
        rd(2'd0, d);
        rd(2'd1, d); chk("R6 selected ch1 lo", d, 8'h66);
        rd(2'd1, d); chk("R6 selected ch1 hi", d, 8'h77);

        // R2 control write resets byte sequencing
        wr(2'd3, cword(0, 3, 0, 0));
        wr(2'd0, 8'h11);
        wr(2'd3, cword(0, 3, 1, 0));
        wr(2'd0, 8'h22);
        chk("R2 write toggle reset", int'(ch_load), 0);
        wr(2'd0, 8'h33);
        chk("R2 reload val", int'(ch_load_val), 16'h3322);
        rd(2'd0, d);
        wr(2'd3, cword(0, 3, 1, 0));
        rd(2'd0, d); chk("R2 read toggle reset", d, live[0][7:0]);

        // R11 control port read
        rd(2'd3, d); chk("R11 ctl read", d, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule